// File: doc/BRIEF.md
# Three-Register Evaluation Stack Unit

This block is the operand stack of a small stack-machine datapath. It keeps exactly three data words, named A (top), B and C, and changes them one operation at a time. A caller presents an operation code and an immediate word and raises the execute strobe for one cycle. The stack is updated at that clock edge, and a done pulse follows one cycle later. The block has no register file. Every operand comes from the three stack words, and the shuffle on push and pop is fixed.

The operations are of two kinds. The first kind takes the immediate as an operand: push a constant, add a constant to the top, and test the top for equality with a constant. The second kind uses no operand. Its code selects from a numbered table of sixteen slots. The block implements swap, add, subtract, difference, product and a signed greater-than, which is the only ordering comparison. Every other code is rejected with an error flag and leaves the stack as it was.

The execute strobe may be held high on consecutive cycles. Each operation then sees the stack as the previous one left it.

Top module: `stk_unit`

## Requirements
- R1: While reset is asserted, and for the cycles in which the internal reset is still being released, A, B and C read 0, and done_o and err_o are 0.
- R2: Push (op_i = 5'b00000) loads A with imm_i, moves the old A into B and the old B into C. The old C is discarded.
- R3: Add-constant (op_i = 5'b00001) writes A + imm_i, modulo 2^W, into A. B and C do not change.
- R4: Equals-constant (op_i = 5'b00010) writes 1 into A if A equals imm_i and 0 otherwise. B and C do not change.
- R5: Swap (op_i = 5'b10000) exchanges A and B. C does not change.
- R6: Add (5'b10101) and subtract (5'b11100) write B + A and B − A, both modulo 2^W, into A. They move C into B and leave C unchanged.
- R7: Difference (5'b10100) writes B − A into A with wraparound and no overflow indication. Product (5'b11000) writes the low W bits of B × A into A. Both pop as in R6.
- R8: Greater-than (5'b11001) compares B and A as signed numbers. It writes 1 into A when B > A and 0 otherwise, and pops as in R6.
- R9: Every other code is unsupported. This covers the primary codes 5'b00011 to 5'b01111 and the operand-free slots 1, 2, 3, 6, 7, 10, 11, 13, 14 and 15 (op_i[4] = 1). Such a code leaves A, B and C unchanged and raises err_o together with done_o.
- R10: done_o is high exactly in the cycle after each cycle in which exec_i was high. An execute strobe held high on back-to-back cycles completes one operation per cycle.
- R11: While exec_i is low, A, B and C hold their values whatever op_i and imm_i carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchroniser |
| exec_i | input | 1 | Execute strobe, one operation per high cycle |
| op_i | input | 5 | Operation: bit 4 = 0 selects an immediate-using code in bits 3:0, bit 4 = 1 selects an operand-free slot 0..15 |
| imm_i | input | W | Immediate constant |
| a_o | output | W | Stack top A |
| b_o | output | W | Stack word B |
| c_o | output | W | Stack bottom C |
| done_o | output | 1 | Completion pulse, one cycle after the execute strobe |
| err_o | output | 1 | Unsupported-code flag, valid with done_o |

## Verification
Two things can coincide in one cycle: the completion of one operation (done_o, err_o and the updated stack) and the acceptance of the next operation, which reads that same updated stack. The bench provokes this by issuing nearly every operation back-to-back: pushes directly followed by arithmetic, and an unsupported code sitting between two supported ones. A reference model in the bench applies each operation in issue order. A monitor compares every done pulse against the queued model state, so a stale operand or a lost or duplicated completion shows up as a mismatch or a count error.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int OPW = 5;

  // immediate-using codes (op[4] == 0)
  localparam logic [3:0] PRI_PUSH = 4'd0;
  localparam logic [3:0] PRI_ADDK = 4'd1;
  localparam logic [3:0] PRI_EQK  = 4'd2;

  // operand-free table slots (op[4] == 1); slot numbers are fixed
  localparam logic [3:0] SEC_SWAP = 4'd0;
  localparam logic [3:0] SEC_DIFF = 4'd4;
  localparam logic [3:0] SEC_ADD  = 4'd5;
  localparam logic [3:0] SEC_MUL  = 4'd8;
  localparam logic [3:0] SEC_GT   = 4'd9;
  localparam logic [3:0] SEC_SUB  = 4'd12;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_PUSH,
    ACT_UNARY,
    ACT_SWAP,
    ACT_BINARY,
    ACT_BAD
  } act_e;

  typedef enum logic [2:0] {
    FN_PASS,
    FN_ADD,
    FN_SUB,
    FN_MUL,
    FN_EQ,
    FN_GT
  } fn_e;

  typedef struct packed {
    act_e act;
    fn_e  fn;
    logic y_imm;
  } dec_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
(
  input  logic           exec_i,
  input  logic [OPW-1:0] op_i,
  output dec_t           dec_o
);

  logic       is_sec;
  logic [3:0] code;

  assign is_sec = op_i[OPW-1];
  assign code   = op_i[3:0];

  always_comb begin
    dec_o.act   = ACT_NONE;
    dec_o.fn    = FN_PASS;
    dec_o.y_imm = 1'b1;
    if (exec_i) begin
      if (!is_sec) begin
        unique case (code)
          PRI_PUSH: begin dec_o.act = ACT_PUSH;  dec_o.fn = FN_PASS; end
          PRI_ADDK: begin dec_o.act = ACT_UNARY; dec_o.fn = FN_ADD;  end
          PRI_EQK:  begin dec_o.act = ACT_UNARY; dec_o.fn = FN_EQ;   end
          default:  dec_o.act = ACT_BAD;
        endcase
      end else begin
        dec_o.y_imm = 1'b0;
        unique case (code)
          SEC_SWAP: dec_o.act = ACT_SWAP;
          SEC_DIFF: begin dec_o.act = ACT_BINARY; dec_o.fn = FN_SUB; end
          SEC_SUB:  begin dec_o.act = ACT_BINARY; dec_o.fn = FN_SUB; end
          SEC_ADD:  begin dec_o.act = ACT_BINARY; dec_o.fn = FN_ADD; end
          SEC_MUL:  begin dec_o.act = ACT_BINARY; dec_o.fn = FN_MUL; end
          SEC_GT:   begin dec_o.act = ACT_BINARY; dec_o.fn = FN_GT;  end
          default:  dec_o.act = ACT_BAD;
        endcase
      end
    end
  end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 32
) (
  input  fn_e          fn_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] r_o
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] prod;
  logic         eq_hit;
  logic         gt_hit;

  assign prod   = x_i * y_i;
  assign eq_hit = (x_i == y_i);
  assign gt_hit = ($signed(x_i) > $signed(y_i));

  always_comb begin
    unique case (fn_i)
      FN_PASS: r_o = y_i;
      FN_ADD:  r_o = x_i + y_i;
      FN_SUB:  r_o = x_i - y_i;
      FN_MUL:  r_o = prod;
      FN_EQ:   r_o = eq_hit ? ONE : ZERO;
      FN_GT:   r_o = gt_hit ? ONE : ZERO;
      default: r_o = y_i;
    endcase
  end

endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  act_e         act_i,
  input  logic [W-1:0] res_i,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] c_q
);

  logic [W-1:0] a_d, b_d, c_d;
  logic         load;

  always_comb begin
    a_d  = a_q;
    b_d  = b_q;
    c_d  = c_q;
    load = 1'b0;
    unique case (act_i)
      ACT_PUSH: begin
        a_d  = res_i;
        b_d  = a_q;
        c_d  = b_q;
        load = 1'b1;
      end
      ACT_UNARY: begin
        a_d  = res_i;
        load = 1'b1;
      end
      ACT_SWAP: begin
        a_d  = b_q;
        b_d  = a_q;
        load = 1'b1;
      end
      ACT_BINARY: begin
        a_d  = res_i;
        b_d  = c_q;
        load = 1'b1;
      end
      default: load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (load) begin
      a_q <= a_d;
      b_q <= b_d;
      c_q <= c_d;
    end
  end

endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_i,
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   imm_i,
  output logic [W-1:0]   a_o,
  output logic [W-1:0]   b_o,
  output logic [W-1:0]   c_o,
  output logic           done_o,
  output logic           err_o
);

  // reset: asserted asynchronously, released through two stages
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dec_t         dec;
  logic [W-1:0] a_q, b_q, c_q;
  logic [W-1:0] alu_x, alu_y, alu_r;

  stk_decode u_dec (
    .exec_i (exec_i),
    .op_i   (op_i),
    .dec_o  (dec)
  );

  // operand routing: pops use B op A, immediates use A op imm
  assign alu_x = (dec.act == ACT_BINARY) ? b_q : a_q;
  assign alu_y = dec.y_imm ? imm_i : a_q;

  stk_alu #(.W(W)) u_alu (
    .fn_i (dec.fn),
    .x_i  (alu_x),
    .y_i  (alu_y),
    .r_o  (alu_r)
  );

  stk_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .act_i (dec.act),
    .res_i (alu_r),
    .a_q   (a_q),
    .b_q   (b_q),
    .c_q   (c_q)
  );

  // completion flags
  logic done_d, err_d, done_q, err_q;

  always_comb begin
    done_d = exec_i;
    err_d  = exec_i && (dec.act == ACT_BAD);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign a_o    = a_q;
  assign b_o    = b_q;
  assign c_o    = c_q;
  assign done_o = done_q;
  assign err_o  = err_q;

endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk
  import stk_pkg::*;
#(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_core_n,
  input logic           exec_i,
  input logic [OPW-1:0] op_i,
  input logic [W-1:0]   imm_i,
  input logic [W-1:0]   a_o,
  input logic [W-1:0]   b_o,
  input logic [W-1:0]   c_o,
  input logic           done_o,
  input logic           err_o
);

  logic is_push, is_eqk, is_swap, is_gt, is_pop, is_known;

  always_comb begin
    is_push = (op_i == {1'b0, PRI_PUSH});
    is_eqk  = (op_i == {1'b0, PRI_EQK});
    is_swap = (op_i == {1'b1, SEC_SWAP});
    is_gt   = (op_i == {1'b1, SEC_GT});
    is_pop  = op_i[4] && (op_i[3:0] == SEC_DIFF || op_i[3:0] == SEC_ADD ||
                          op_i[3:0] == SEC_MUL  || op_i[3:0] == SEC_GT  ||
                          op_i[3:0] == SEC_SUB);
    is_known = is_push || is_swap || is_pop ||
               (op_i == {1'b0, PRI_ADDK}) || is_eqk;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_core_n |-> (a_o == '0 && b_o == '0 && c_o == '0 && !done_o && !err_o));

  // R2
  push_shuffle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    exec_i && is_push |=> a_o == $past(imm_i) && b_o == $past(a_o) && c_o == $past(b_o));

  // R4
  eq_bool_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    exec_i && is_eqk |=> a_o[W-1:1] == '0 && a_o[0] == ($past(a_o) == $past(imm_i)));

  // R5
  swap_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    exec_i && is_swap |=> a_o == $past(b_o) && b_o == $past(a_o) && $stable(c_o));

  // R6
  pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    exec_i && is_pop |=> b_o == $past(c_o) && $stable(c_o));

  // R8
  gt_bool_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    exec_i && is_gt |=> a_o[W-1:1] == '0);

  // R9
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    exec_i && !is_known |=> $stable(a_o) && $stable(b_o) && $stable(c_o) && err_o);

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    exec_i |=> done_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !exec_i |=> !done_o && !err_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !exec_i |=> $stable(a_o) && $stable(b_o) && $stable(c_o));

endmodule

bind stk_unit stk_unit_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .exec_i     (exec_i),
  .op_i       (op_i),
  .imm_i      (imm_i),
  .a_o        (a_o),
  .b_o        (b_o),
  .c_o        (c_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/stk_unit_bench.sv
module stk_unit_bench;

  localparam int  W        = 32;
  localparam time T_CLK    = 10ns;
  localparam int  WATCHDOG = 20000;

  // operation codes, as listed in the requirements
  localparam logic [4:0] OP_PUSH = 5'b00000;
  localparam logic [4:0] OP_ADDK = 5'b00001;
  localparam logic [4:0] OP_EQK  = 5'b00010;
  localparam logic [4:0] OP_SWAP = 5'b10000;
  localparam logic [4:0] OP_DIFF = 5'b10100;
  localparam logic [4:0] OP_ADD  = 5'b10101;
  localparam logic [4:0] OP_MUL  = 5'b11000;
  localparam logic [4:0] OP_GT   = 5'b11001;
  localparam logic [4:0] OP_SUB  = 5'b11100;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         exec_i;
  logic [4:0]   op_i;
  logic [W-1:0] imm_i;
  logic [W-1:0] a_o, b_o, c_o;
  logic         done_o, err_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] a, b, c;
    logic         err;
    string        req;
  } exp_t;

  exp_t exp_q[$];
  logic [W-1:0] ma, mb, mc;

  always #(T_CLK/2) clk = ~clk;

  stk_unit #(.W(W)) u_stk_unit (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec_i (exec_i),
    .op_i   (op_i),
    .imm_i  (imm_i),
    .a_o    (a_o),
    .b_o    (b_o),
    .c_o    (c_o),
    .done_o (done_o),
    .err_o  (err_o)
  );

  function automatic logic [W-1:0] bool_w(input logic v);
    return v ? {{(W-1){1'b0}}, 1'b1} : '0;
  endfunction

  // driver: one operation per call, back-to-back capable
  task automatic issue(input logic [4:0] op, input logic [W-1:0] imm, input string req);
    exp_t e;
    logic bad;
    @(negedge clk);
    exec_i = 1'b1;
    op_i   = op;
    imm_i  = imm;
    bad    = 1'b0;
    case (op)
      OP_PUSH: begin mc = mb; mb = ma; ma = imm; end
      OP_ADDK: ma = ma + imm;
      OP_EQK:  ma = bool_w(ma == imm);
      OP_SWAP: begin logic [W-1:0] t; t = ma; ma = mb; mb = t; end
      OP_ADD:  begin ma = mb + ma; mb = mc; end
      OP_SUB:  begin ma = mb - ma; mb = mc; end
      OP_DIFF: begin ma = mb - ma; mb = mc; end
      OP_MUL:  begin ma = mb * ma; mb = mc; end
      OP_GT:   begin ma = bool_w($signed(mb) > $signed(ma)); mb = mc; end
      default: bad = 1'b1;
    endcase
    e.a = ma; e.b = mb; e.c = mc; e.err = bad; e.req = req;
    exp_q.push_back(e);
  endtask

  // idle stretch with junk on op/imm; outputs must stay put
  task automatic idle_check(input logic [4:0] op, input logic [W-1:0] imm);
    @(negedge clk);
    exec_i = 1'b0;
    op_i   = op;
    imm_i  = imm;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (done_o !== 1'b0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 idle done/err: got %b/%b expected 0/0", done_o, err_o);
    end
    checks++;
    if (a_o !== ma || b_o !== mb || c_o !== mc) begin
      errors++;
      $display("FAIL R11 idle hold: got %h %h %h expected %h %h %h",
               a_o, b_o, c_o, ma, mb, mc);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && done_o === 1'b1) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected done: got 1 expected 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (a_o !== e.a || b_o !== e.b || c_o !== e.c || err_o !== e.err) begin
            errors++;
            $display("FAIL %s: got A=%h B=%h C=%h err=%b expected A=%h B=%h C=%h err=%b",
                     e.req, a_o, b_o, c_o, err_o, e.a, e.b, e.c, e.err);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    exec_i = 1'b0;
    op_i   = 5'b00000;
    imm_i  = '0;
    ma = '0; mb = '0; mc = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (a_o !== '0 || b_o !== '0 || c_o !== '0 || done_o !== 1'b0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: got %h %h %h %b %b expected all zero",
               a_o, b_o, c_o, done_o, err_o);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: pushes, fourth push drops the oldest word
    issue(OP_PUSH, 32'd5,  "R2 push");
    issue(OP_PUSH, 32'd7,  "R2 push");
    issue(OP_PUSH, 32'd9,  "R2 push");
    issue(OP_PUSH, 32'd11, "R2 push drops C");
    // R3: add-constant wraps
    issue(OP_ADDK, 32'hFFFF_FFFF, "R3 addk wrap");
    issue(OP_ADDK, 32'd100, "R3 addk");
    // R4: equality true and false
    issue(OP_EQK,  32'd110, "R4 eqk true");
    issue(OP_PUSH, 32'd3,   "R2 push");
    issue(OP_EQK,  32'd4,   "R4 eqk false");
    // R5: swap
    issue(OP_PUSH, 32'hDEAD_BEEF, "R2 push");
    issue(OP_SWAP, 32'd0, "R5 swap");
    idle_check(OP_ADD, 32'h1234);
    // R6: subtract and add with wrap, B op A order
    issue(OP_PUSH, 32'd0, "R2 push");
    issue(OP_PUSH, 32'd1, "R2 push");
    issue(OP_SUB,  32'd0, "R6 sub wrap");
    issue(OP_PUSH, 32'd2, "R2 push");
    issue(OP_ADD,  32'd0, "R6 add wrap");
    issue(OP_PUSH, 32'd50, "R2 push");
    issue(OP_PUSH, 32'd8,  "R2 push");
    issue(OP_SUB,  32'd0,  "R6 sub order");
    // R9: unsupported codes between supported ones
    issue(5'b10001, 32'd0, "R9 slot1 unsupported");
    issue(5'b00101, 32'd77, "R9 primary unsupported");
    issue(5'b10111, 32'd0, "R9 slot7 unsupported");
    issue(5'b11111, 32'd0, "R9 slot15 unsupported");
    // R7: difference and product
    issue(OP_PUSH, 32'h8000_0000, "R2 push");
    issue(OP_PUSH, 32'd1, "R2 push");
    issue(OP_DIFF, 32'd0, "R7 diff no overflow flag");
    issue(OP_PUSH, 32'h0001_0001, "R2 push");
    issue(OP_PUSH, 32'h0001_0003, "R2 push");
    issue(OP_MUL,  32'd0, "R7 product low word");
    idle_check(OP_PUSH, 32'hFFFF);
    // R8: signed greater-than
    issue(OP_PUSH, 32'hFFFF_FFFF, "R2 push");
    issue(OP_PUSH, 32'd1, "R2 push");
    issue(OP_GT,   32'd0, "R8 gt signed negative");
    issue(OP_PUSH, 32'd5, "R2 push");
    issue(OP_PUSH, 32'd3, "R2 push");
    issue(OP_GT,   32'd0, "R8 gt true");
    issue(OP_PUSH, 32'd4, "R2 push");
    issue(OP_PUSH, 32'd4, "R2 push");
    issue(OP_GT,   32'd0, "R8 gt equal");
    idle_check(OP_SWAP, 32'd0);

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing done: got %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule